// File: doc/BRIEF.md
# Double-Buffered Audio Word Sequencer

This block decides which memory word each audio sample travels to or from. Software programs a receive pointer, a transmit pointer and one word count that both directions share. A start command copies each enabled pointer into a private working pointer. On every word slot that the serializer announces, the block then emits one word address and strobe per enabled direction, stepping by four bytes until the count is used up.

Each time a working pointer is refreshed from its software register, the block raises a sticky pointer-taken flag for that direction. Software can then write the next buffer address while the current one drains. When a buffer ends, the next slot continues at once from whatever the pointer register holds, so back-to-back buffers play without a gap. A stop command lets the word in flight finish, then halts and raises a stopped flag. An interrupt line reports any flag whose enable is set.

Top module: `xfer_seq`

## Requirements
- R1: After reset, both strobes, both addresses, the interrupt line and every readable register are zero.
- R2: A start command while idle with a nonzero count copies the pointer of each enabled direction into its working pointer. It sets that direction's pointer-taken flag: receive flag at register index 6, transmit flag at index 7.
- R3: While running, each slot tick yields one strobe per enabled direction in the next cycle. The address is working pointer + 4*k, with k counting 0 to count-1 within a buffer.
- R4: Configuration register index 5 enables receive with bit 0 and transmit with bit 1. A cleared direction produces no strobe and no pointer-taken flag.
- R5: On the slot after a buffer's last word, addressing continues from the value the pointer register holds when the last word is issued, with no idle slot. The pointer-taken flag of that direction is set again.
- R6: A pointer register written while a buffer is in progress does not change that buffer's addresses.
- R7: A stop command (index 1) while running lets no further word start. The next slot tick issues no strobe, ends the run and sets the stopped flag (index 8). A stop while idle sets the stopped flag directly.
- R8: A start command (index 0) with a count of zero (index 4) is ignored: no flag and no strobes follow.
- R9: Flags are sticky. Writing zero to a flag's index clears it, and writing a nonzero value leaves it unchanged.
- R10: Interrupt enables use bit 0 for receive pointer-taken, bit 1 for transmit pointer-taken and bit 2 for stopped. Writing ones to index 9 sets enables and writing ones to index 10 clears them. Reading either index returns the enables.
- R11: The interrupt line is high one cycle after any flag is set whose enable is set, and low when no such flag remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for write and readback |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered readback of reg_addr |
| slot_tick | input | 1 | One-cycle pulse per word slot from the serializer |
| rx_stb_o | output | 1 | Receive word strobe |
| rx_addr_o | output | 32 | Receive word byte address |
| tx_stb_o | output | 1 | Transmit word strobe |
| tx_addr_o | output | 32 | Transmit word byte address |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that slot_tick is a single-cycle pulse. They also assume that the configuration and count stay fixed while a run is active, so that a strobe can be traced back to a tick and an enable seen in the preceding cycle. The bench spaces ticks several cycles apart, changes configuration and count only between runs, and drives all inputs on the falling edge. It sweeps every count from one to four against every combination of enabled directions. It rewrites pointers only while a buffer is in progress, so that R5 and R6 can be told apart arithmetically.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int ADDR_W = 32;
  localparam int NUM_EV = 3;

  typedef enum logic [3:0] {
    IDX_START  = 4'd0,
    IDX_STOP   = 4'd1,
    IDX_RXPTR  = 4'd2,
    IDX_TXPTR  = 4'd3,
    IDX_COUNT  = 4'd4,
    IDX_CFG    = 4'd5,
    IDX_EV_RX  = 4'd6,
    IDX_EV_TX  = 4'd7,
    IDX_EV_STP = 4'd8,
    IDX_IESET  = 4'd9,
    IDX_IECLR  = 4'd10
  } reg_idx_t;
endpackage

// File: rtl/xfer_walk.sv
module xfer_walk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] src_ptr,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] addr_o,
  output logic          stb_o,
  output logic          upd_o
);
  logic [AW-1:0] work_ptr;
  logic [CW-1:0] idx;
  logic [CW:0]   idx_nx;

  assign idx_nx = {1'b0, idx} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      work_ptr <= '0;
      idx      <= '0;
      addr_o   <= '0;
      stb_o    <= 1'b0;
      upd_o    <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      upd_o <= 1'b0;
      if (load) begin
        work_ptr <= src_ptr;
        idx      <= '0;
        upd_o    <= 1'b1;
      end else if (step) begin
        stb_o  <= 1'b1;
        addr_o <= work_ptr + (AW'(idx) << 2);
        if (idx_nx >= {1'b0, count}) begin
          idx      <= '0;
          work_ptr <= src_ptr;
          upd_o    <= 1'b1;
        end else begin
          idx <= idx_nx[CW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/xfer_regs.sv
module xfer_regs
  import xfer_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_EV-1:0] ev_set,
  output logic              start_cmd,
  output logic              stop_cmd,
  output logic [AW-1:0]     rx_ptr,
  output logic [AW-1:0]     tx_ptr,
  output logic [CW-1:0]     count,
  output logic [1:0]        cfg_en,
  output logic [NUM_EV-1:0] ev_flags,
  output logic              irq_o
);
  logic [NUM_EV-1:0] ie;

  assign start_cmd = reg_we && (reg_addr == IDX_START);
  assign stop_cmd  = reg_we && (reg_addr == IDX_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ptr <= '0;
      tx_ptr <= '0;
      count  <= '0;
      cfg_en <= '0;
      ie     <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        IDX_RXPTR: rx_ptr <= reg_wdata[AW-1:0];
        IDX_TXPTR: tx_ptr <= reg_wdata[AW-1:0];
        IDX_COUNT: count  <= reg_wdata[CW-1:0];
        IDX_CFG:   cfg_en <= reg_wdata[1:0];
        IDX_IESET: ie     <= ie | reg_wdata[NUM_EV-1:0];
        IDX_IECLR: ie     <= ie & ~reg_wdata[NUM_EV-1:0];
        default:   ;
      endcase
    end
  end

  for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
    localparam logic [3:0] EV_IDX = 4'(IDX_EV_RX) + 4'(e);
    always_ff @(posedge clk) begin
      if (rst)
        ev_flags[e] <= 1'b0;
      else if (ev_set[e])
        ev_flags[e] <= 1'b1;
      else if (reg_we && reg_addr == EV_IDX && reg_wdata == '0)
        ev_flags[e] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= |(ev_flags & ie);
      case (reg_addr)
        IDX_RXPTR:            reg_rdata <= 32'(rx_ptr);
        IDX_TXPTR:            reg_rdata <= 32'(tx_ptr);
        IDX_COUNT:            reg_rdata <= 32'(count);
        IDX_CFG:              reg_rdata <= 32'(cfg_en);
        IDX_EV_RX:            reg_rdata <= 32'(ev_flags[0]);
        IDX_EV_TX:            reg_rdata <= 32'(ev_flags[1]);
        IDX_EV_STP:           reg_rdata <= 32'(ev_flags[2]);
        IDX_IESET, IDX_IECLR: reg_rdata <= 32'(ie);
        default:              reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              slot_tick,
  output logic              rx_stb_o,
  output logic [ADDR_W-1:0] rx_addr_o,
  output logic              tx_stb_o,
  output logic [ADDR_W-1:0] tx_addr_o,
  output logic              irq_o
);
  localparam int NDIR = 2;

  logic              start_cmd, stop_cmd;
  logic [ADDR_W-1:0] rx_ptr, tx_ptr;
  logic [CW-1:0]     count;
  logic [1:0]        cfg_en;
  logic [NUM_EV-1:0] ev_flags;
  logic              running, stop_pend, stopped_pulse;
  logic              do_start, end_tick;

  logic [ADDR_W-1:0] ptr_d  [NDIR];
  logic [ADDR_W-1:0] addr_d [NDIR];
  logic [NDIR-1:0]   stb_d, upd_d;

  assign do_start = start_cmd && !running && (count != '0);
  assign end_tick = running && stop_pend && slot_tick;
  assign ptr_d[0] = rx_ptr;
  assign ptr_d[1] = tx_ptr;

  xfer_regs #(.AW(ADDR_W), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_set({stopped_pulse, upd_d}), .start_cmd(start_cmd),
    .stop_cmd(stop_cmd), .rx_ptr(rx_ptr), .tx_ptr(tx_ptr), .count(count),
    .cfg_en(cfg_en), .ev_flags(ev_flags), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      running       <= 1'b0;
      stop_pend     <= 1'b0;
      stopped_pulse <= 1'b0;
    end else begin
      stopped_pulse <= 1'b0;
      if (do_start) begin
        running   <= 1'b1;
        stop_pend <= 1'b0;
      end else if (end_tick) begin
        running       <= 1'b0;
        stop_pend     <= 1'b0;
        stopped_pulse <= 1'b1;
      end else if (stop_cmd) begin
        if (running) stop_pend     <= 1'b1;
        else         stopped_pulse <= 1'b1;
      end
    end
  end

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xfer_walk #(.AW(ADDR_W), .CW(CW)) u_walk (
      .clk(clk), .rst(rst),
      .load(do_start && cfg_en[d]),
      .step(running && !stop_pend && slot_tick && cfg_en[d]),
      .src_ptr(ptr_d[d]), .count(count),
      .addr_o(addr_d[d]), .stb_o(stb_d[d]), .upd_o(upd_d[d])
    );
  end

  assign rx_stb_o  = stb_d[0];
  assign rx_addr_o = addr_d[0];
  assign tx_stb_o  = stb_d[1];
  assign tx_addr_o = addr_d[1];
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       slot_tick,
  input logic       rx_stb,
  input logic       tx_stb,
  input logic       running,
  input logic [1:0] cfg,
  input logic [2:0] ev,
  input logic       irq
);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(running) |-> (!rx_stb && !tx_stb));

  a_r3_stb_needs_tick: assert property (@(posedge clk) disable iff (rst)
    (rx_stb || tx_stb) |-> $past(slot_tick));

  a_r4_rx_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    rx_stb |-> $past(cfg[0]));

  a_r4_tx_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    tx_stb |-> $past(cfg[1]));

  a_r7_stopped_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(ev[2]) |-> !running);

  a_r11_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|ev));
endmodule

bind xfer_seq xfer_seq_chk u_chk (
  .clk(clk), .rst(rst), .slot_tick(slot_tick), .rx_stb(rx_stb_o),
  .tx_stb(tx_stb_o), .running(running), .cfg(cfg_en), .ev(ev_flags),
  .irq(irq_o)
);

// File: tb/xfer_seq_tb.sv
`timescale 1ns/1ps
module xfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        slot_tick = 1'b0;
  logic        rx_stb_o, tx_stb_o, irq_o;
  logic [31:0] rx_addr_o, tx_addr_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  xfer_seq u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slot_tick(slot_tick),
    .rx_stb_o(rx_stb_o), .rx_addr_o(rx_addr_o), .tx_stb_o(tx_stb_o),
    .tx_addr_o(tx_addr_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // one tick; strobes sampled on the following falling edge
  task automatic tick(output logic rs, output logic [31:0] ra,
                      output logic ts, output logic [31:0] ta);
    @(negedge clk);
    slot_tick = 1'b1;
    @(negedge clk);
    slot_tick = 1'b0;
    rs = rx_stb_o; ra = rx_addr_o; ts = tx_stb_o; ta = tx_addr_o;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, ra, ta;
    logic rs, ts;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rx_stb", 32'(rx_stb_o), 0);
    chk("R1 tx_stb", 32'(tx_stb_o), 0);
    chk("R1 rx_addr", rx_addr_o, 0);
    chk("R1 irq", 32'(irq_o), 0);
    for (int i = 0; i <= 10; i++) begin
      rd(4'(i), v);
      chk("R1 register", v, 0);
    end

    // R10 enable set/clear
    wr(4'd9, 32'h5);
    rd(4'd9, v);  chk("R10 set readback", v, 32'h5);
    wr(4'd10, 32'h1);
    rd(4'd10, v); chk("R10 clear readback", v, 32'h4);
    wr(4'd9, 32'h3);
    rd(4'd9, v);  chk("R10 set accumulates", v, 32'h7);
    wr(4'd10, 32'h7);

    // R8 zero count ignored
    wr(4'd5, 32'h3);
    wr(4'd2, 32'h100);
    wr(4'd3, 32'h200);
    wr(4'd0, 32'h1);
    tick(rs, ra, ts, ta);
    chk("R8 no rx strobe", 32'(rs), 0);
    chk("R8 no tx strobe", 32'(ts), 0);
    rd(4'd6, v); chk("R8 no rx flag", v, 0);

    // R7 stop while idle
    wr(4'd1, 32'h1);
    rd(4'd8, v); chk("R7 idle stop flag", v, 1);
    // R9 nonzero write ignored, zero clears
    wr(4'd8, 32'h1);
    rd(4'd8, v); chk("R9 nonzero keeps flag", v, 1);
    wr(4'd8, 32'h0);
    rd(4'd8, v); chk("R9 zero clears flag", v, 0);

    // sweep: counts 1..4, enable combinations 1..3
    for (int cnt = 1; cnt <= 4; cnt++) begin
      for (int en = 1; en <= 3; en++) begin
        logic [31:0] rp0, rp1, tp0, tp1, erx, etx;
        rp0 = 32'h1000 + 32'(cnt) * 32'h100; rp1 = rp0 + 32'h4000;
        tp0 = 32'h8000 + 32'(en) * 32'h40;   tp1 = tp0 + 32'h2000;
        wr(4'd4, 32'(cnt));
        wr(4'd5, 32'(en));
        wr(4'd2, rp0);
        wr(4'd3, tp0);
        wr(4'd0, 32'h1);
        rd(4'd6, v); chk("R2 rx flag after start", v, 32'(en & 1));
        rd(4'd7, v); chk("R2 tx flag after start", v, 32'((en >> 1) & 1));
        wr(4'd6, 0);
        wr(4'd7, 0);
        // R6: new pointers written while first buffer is active
        wr(4'd2, rp1);
        wr(4'd3, tp1);
        for (int j = 0; j < 2 * cnt + 1; j++) begin
          erx = ((j < cnt) ? rp0 : rp1) + 32'(4 * (j % cnt));
          etx = ((j < cnt) ? tp0 : tp1) + 32'(4 * (j % cnt));
          tick(rs, ra, ts, ta);
          if (j == cnt - 1) begin
            rd(4'd6, v); chk("R5 rx flag at buffer end", v, 32'(en & 1));
          end
          chk("R3/R4 rx strobe", 32'(rs), 32'(en & 1));
          chk("R3/R4 tx strobe", 32'(ts), 32'((en >> 1) & 1));
          if (en[0]) chk("R3/R5/R6 rx address", ra, erx);
          if (en[1]) chk("R3/R5/R6 tx address", ta, etx);
        end
        // R7 stop while running
        wr(4'd1, 32'h1);
        rd(4'd8, v); chk("R7 no stop flag before tick", v, 0);
        tick(rs, ra, ts, ta);
        chk("R7 no rx strobe on stop tick", 32'(rs), 0);
        chk("R7 no tx strobe on stop tick", 32'(ts), 0);
        rd(4'd8, v); chk("R7 stopped flag", v, 1);
        tick(rs, ra, ts, ta);
        chk("R7 halted", 32'(rs | ts), 0);
        wr(4'd6, 0); wr(4'd7, 0); wr(4'd8, 0);
      end
    end

    // R11 interrupt
    chk("R11 irq low no flags", 32'(irq_o), 0);
    wr(4'd1, 32'h1);
    repeat (2) @(negedge clk);
    chk("R11 irq low when masked", 32'(irq_o), 0);
    wr(4'd9, 32'h4);
    repeat (2) @(negedge clk);
    chk("R11 irq high", 32'(irq_o), 1);
    wr(4'd8, 32'h0);
    repeat (2) @(negedge clk);
    chk("R11 irq low after clear", 32'(irq_o), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule